// File: doc/BRIEF.md
# Fractional M/N:D clock divider

This block generates a peripheral clock from one of up to eight source clocks. Each source is modelled as a single-cycle enable on one fast system clock. A selectable pre-divider thins the chosen source. It passes every source tick through, divides by a whole number, or divides by a half-integer ratio by alternating between two tick counts. A fractional M/N counter then turns the pre-divided ticks into a clock level whose duty is set by a D value. That level leaves the block twice: once raw, and once through a branch gate.

Software programs staged copies of M, N, D and a configuration word through a simple write/read register port. N is written as the bitwise inverse of (N − M), and D as the bitwise inverse of D. Nothing staged reaches the counters until software sets the update bit in the command register. Hardware holds that bit at 1 and commits all staged values together at the next output period boundary, or after a fixed cycle bound if no boundary comes. It then restarts every counter from zero and clears the bit, so software can poll it with a bounded loop. The branch gate register is not staged and acts at once.

Top module: `mnd_clk_root`

## Requirements
- R1: A synchronous active-high reset clears every register, including the staged and active copies, the update bit and the branch enable. After reset every register reads 0, and both clock outputs are 0, in pre-divider bypass with source 0.
- R2: Register addresses: 0 = M, 1 = inverted (N − M), 2 = inverted D, 3 = configuration, 4 = command, 5 = branch gate. The configuration word places the pre-divider code in bits 4:0, the source select in bits 10:8 and the counter mode in bits 13:12. A read returns the staged value one cycle after the address is presented. The command register reads the update bit in bit 0.
- R3: In mode 2 the effective N is ~Nreg + M and the effective D is ~Dreg. On the k-th pre-divided tick after a commit (k = 0, 1, ...), the level goes high when (k·M mod N) < D and low otherwise.
- R4: The effective D is clamped into the range 1 to N−1. A programmed D of 0 behaves as 1, and a programmed D of N or more behaves as N−1.
- R5: Pre-divider code 0 passes every source tick. An odd code c divides by (c+1)/2. An even nonzero code c alternates periods of c/2 and c/2+1 source ticks, starting with the shorter one, so it gives two ticks every c+1 source ticks.
- R6: The source select field picks which src_tick bit feeds the pre-divider.
- R7: In any mode other than 2, the level toggles on every pre-divided tick.
- R8: Writing 1 to command bit 0 sets the update bit, which reads back as 1. Staged M, N, D and configuration values have no effect on the outputs until a commit.
- R9: A commit happens at an output period boundary, or after UPD_TMO cycles, whichever comes first. It clears the update bit and restarts all counters from zero. The update bit is never set for more than UPD_TMO cycles.
- R10: clk_out follows clk_level while bit 0 of the branch gate register is 1, and it is held at 0 while that bit is 0. Writing 1 to an already-set gate bit leaves clk_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; source ticks are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Registered read data, valid one cycle after rd_addr |
| src_tick | input | NSRC | Per-source tick enables |
| clk_level | output | 1 | Divided clock level (registered) |
| clk_out | output | 1 | Branch-gated divided clock (registered) |

## Verification
A wrong accumulator or a wrong D clamp shows up as a wrong number of rising edges, or wrong high time, in clk_level over one full pattern period of N output ticks. It is therefore visible within one output period after a commit. A pre-divider that picks the wrong tick count, or the wrong source, changes the length of that period, and the edge count over a window of fixed length exposes it. A faulty update path shows up in one of three ways, each visible within one timeout window: the update bit stays set past the bound, it clears before the boundary it should wait for, or staged values leak to the output before a commit.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

  localparam int ADDR_W = 3;
  localparam int DIV_W  = 5;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_MVAL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_NINV = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DINV = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_GATE = 3'd5;

  localparam logic [1:0] MODE_MND = 2'd2;

  typedef struct packed {
    logic [1:0]       mode;
    logic [SEL_W-1:0] src;
    logic [DIV_W-1:0] div;
  } cfg_t;

endpackage

// File: rtl/mnd_regs.sv
module mnd_regs
  import mnd_pkg::*;
#(
  parameter int CW      = 8,
  parameter int DW      = 16,
  parameter int UPD_TMO = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              period_end,
  output logic              commit,
  output logic [CW-1:0]     act_m,
  output logic [CW-1:0]     act_ninv,
  output logic [CW-1:0]     act_dinv,
  output cfg_t              act_cfg,
  output logic              gate_en
);

  localparam int TW = $clog2(UPD_TMO + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(UPD_TMO - 1);

  logic [CW-1:0] sh_m, sh_ninv, sh_dinv;
  cfg_t          sh_cfg;
  logic          busy;
  logic [TW-1:0] wait_cnt;
  logic [DW-1:0] rd_mux;
  logic [13:0]   cfg_word;
  logic          unused_wbits;

  assign unused_wbits = ^{wr_data[DW-1:14], wr_data[11]};

  // commit at the active config's period end, or when the wait bound runs out
  assign commit = busy && (period_end || (wait_cnt == TMO_LAST));

  assign cfg_word = {sh_cfg.mode, 1'b0, sh_cfg.src, 3'b000, sh_cfg.div};

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADR_MVAL: rd_mux = DW'(sh_m);
      ADR_NINV: rd_mux = DW'(sh_ninv);
      ADR_DINV: rd_mux = DW'(sh_dinv);
      ADR_CFG:  rd_mux = DW'(cfg_word);
      ADR_CMD:  rd_mux = DW'(busy);
      ADR_GATE: rd_mux = DW'(gate_en);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_m     <= '0;
      sh_ninv  <= '0;
      sh_dinv  <= '0;
      sh_cfg   <= '0;
      act_m    <= '0;
      act_ninv <= '0;
      act_dinv <= '0;
      act_cfg  <= '0;
      gate_en  <= 1'b0;
      busy     <= 1'b0;
      wait_cnt <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADR_MVAL: sh_m    <= wr_data[CW-1:0];
          ADR_NINV: sh_ninv <= wr_data[CW-1:0];
          ADR_DINV: sh_dinv <= wr_data[CW-1:0];
          ADR_CFG:  sh_cfg  <= '{mode: wr_data[13:12], src: wr_data[10:8], div: wr_data[4:0]};
          ADR_GATE: gate_en <= wr_data[0];
          default: ;
        endcase
      end
      if (commit) begin
        act_m    <= sh_m;
        act_ninv <= sh_ninv;
        act_dinv <= sh_dinv;
        act_cfg  <= sh_cfg;
        busy     <= 1'b0;
        wait_cnt <= '0;
      end else if (busy) begin
        wait_cnt <= wait_cnt + TW'(1);
      end else if (wr_en && (wr_addr == ADR_CMD) && wr_data[0]) begin
        busy <= 1'b1;
      end
      rd_data <= rd_mux;
    end
  end

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (wait_cnt < TW'(UPD_TMO)));

  // R9
  commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_m != $past(act_m)) || (act_cfg != $past(act_cfg))) |-> $past(commit));

endmodule

// File: rtl/mnd_prediv.sv
module mnd_prediv #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick_in,
  input  logic [PW-1:0] div,
  output logic          tick_out
);

  logic [PW-1:0] cnt;
  logic [PW-1:0] target;
  logic          ph;
  logic          bypass;

  assign bypass = (div == '0);
  // odd code: whole ratio base+1; even code: base, then base+1, alternating
  assign target = {1'b0, div[PW-1:1]} + PW'(div[0] | ph);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      ph       <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (tick_in) begin
        if (bypass) begin
          tick_out <= 1'b1;
        end else if (cnt + PW'(1) == target) begin
          tick_out <= 1'b1;
          cnt      <= '0;
          ph       <= ~ph;
        end else begin
          cnt <= cnt + PW'(1);
        end
      end
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> (cnt < target));

  // R5
  tick_follow_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(tick_in));

endmodule

// File: rtl/mnd_mn_core.sv
module mnd_mn_core #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] m,
  input  logic [CW-1:0] ninv,
  input  logic [CW-1:0] dinv,
  input  logic          mode_mnd,
  output logic          level,
  output logic          period_end
);

  logic [CW-1:0] acc;
  logic [CW-1:0] n_rec, n_eff, d_rec, d_cap, d_eff;
  logic [CW:0]   sum, nx;
  logic [CW-1:0] acc_nx;
  logic          lvl_n;
  logic          unused_carry;

  assign n_rec = ~ninv + m;
  assign n_eff = (n_rec == '0) ? CW'(1) : n_rec;
  assign d_rec = ~dinv;
  assign d_cap = (d_rec >= n_eff) ? (n_eff - CW'(1)) : d_rec;
  assign d_eff = (d_cap == '0) ? CW'(1) : d_cap;

  assign sum          = {1'b0, acc} + {1'b0, m};
  assign nx           = (sum >= {1'b0, n_eff}) ? (sum - {1'b0, n_eff}) : sum;
  assign acc_nx       = nx[CW-1:0];
  assign unused_carry = nx[CW];

  assign lvl_n      = mode_mnd ? (acc < d_eff) : ~level;
  assign period_end = tick && (mode_mnd ? (acc_nx == '0) : level);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc   <= '0;
      level <= 1'b0;
    end else if (tick) begin
      level <= lvl_n;
      acc   <= mode_mnd ? acc_nx : '0;
    end
  end

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (m < n_eff) |-> (acc < n_eff));

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && !mode_mnd) |=> (level != $past(level)));

endmodule

// File: rtl/mnd_clk_root.sv
module mnd_clk_root
  import mnd_pkg::*;
#(
  parameter int CW      = 8,
  parameter int DW      = 16,
  parameter int NSRC    = 8,
  parameter int UPD_TMO = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NSRC-1:0]   src_tick,
  output logic              clk_level,
  output logic              clk_out
);

  localparam int SEL_SPAN = 1 << SEL_W;

  logic [CW-1:0]       act_m, act_ninv, act_dinv;
  cfg_t                act_cfg;
  logic                gate_en, commit, period_end;
  logic                pd_tick, core_level, sel_tick;
  logic [SEL_SPAN-1:0] src_pad;

  always_comb begin
    src_pad           = '0;
    src_pad[NSRC-1:0] = src_tick;
    sel_tick          = src_pad[act_cfg.src];
  end

  mnd_regs #(.CW(CW), .DW(DW), .UPD_TMO(UPD_TMO)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .period_end(period_end), .commit(commit),
    .act_m(act_m), .act_ninv(act_ninv), .act_dinv(act_dinv), .act_cfg(act_cfg),
    .gate_en(gate_en)
  );

  mnd_prediv #(.PW(DIV_W)) prediv_i (
    .clk(clk), .rst(rst), .restart(commit), .tick_in(sel_tick),
    .div(act_cfg.div), .tick_out(pd_tick)
  );

  mnd_mn_core #(.CW(CW)) core_i (
    .clk(clk), .rst(rst), .restart(commit), .tick(pd_tick),
    .m(act_m), .ninv(act_ninv), .dinv(act_dinv),
    .mode_mnd(act_cfg.mode == MODE_MND), .level(core_level), .period_end(period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_level <= 1'b0;
      clk_out   <= 1'b0;
    end else begin
      clk_level <= core_level;
      clk_out   <= core_level & gate_en;
    end
  end

  // R10
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    clk_out |-> $past(gate_en));

endmodule

// File: tb/mnd_clk_root_tb_top.sv
module mnd_clk_root_tb_top;

  localparam int CW = 8, DW = 16, NSRC = 8, TMO = 64;

  typedef struct packed { int m; int n; int d; int f; int src; int mode; } vec_t;

  // stimulus: M, N, D, pre-divider code, source, mode; expectations follow from R3..R7
  localparam vec_t VECS [10] = '{
    '{1, 4, 2,  0, 0, 2},
    '{2, 5, 2,  0, 1, 2},
    '{1, 4, 2, 20, 0, 2},
    '{3, 7, 4,  3, 2, 2},
    '{1, 3, 0,  0, 3, 2},
    '{1, 4, 9,  0, 0, 2},
    '{1, 2, 1,  2, 4, 2},
    '{1, 4, 2, 20, 0, 0},
    '{1, 4, 2,  5, 7, 0},
    '{1, 4, 2,  0, 0, 1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [2:0]      rd_addr = '0;
  logic [DW-1:0]   rd_data;
  logic [NSRC-1:0] src_tick = '0;
  logic            clk_level, clk_out;

  int  n_chk = 0, n_bad = 0, cyc = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  mnd_clk_root #(.CW(CW), .DW(DW), .NSRC(NSRC), .UPD_TMO(TMO)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_tick(src_tick),
    .clk_level(clk_level), .clk_out(clk_out)
  );

  // source i ticks once every i+1 system cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NSRC; i++) src_tick[i] <= ((cyc % (i + 1)) == 0);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_addr = a[2:0];
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic poll_busy();
    int v, polls;
    polls = 0;
    do begin rd(4, v); polls++; end while ((v & 1) && polls < 1000);
  endtask

  task automatic stage(int m, int n, int d, int f, int src, int mode);
    wr(0, m);
    wr(1, (~(n - m)) & 8'hFF);
    wr(2, (~d) & 8'hFF);
    wr(3, f | (src << 8) | (mode << 12));
  endtask

  task automatic measure(int w, bit settle, output int rises, output int highs,
                         output int mism, output int outh);
    logic prev;
    rises = 0; highs = 0; mism = 0; outh = 0;
    if (settle) repeat (w) @(negedge clk);
    @(negedge clk);
    prev = clk_level;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      if (clk_level && !prev) rises++;
      if (clk_level) highs++;
      if (clk_out) outh++;
      if (clk_out != clk_level) mism++;
      prev = clk_level;
    end
  endtask

  // per N ticks: rising edges and high ticks of the sequence (k*M mod N) < Deff
  function automatic void model(int m, int n, int d, output int r, output int h);
    int deff;
    bit cur, prv;
    deff = (d >= n) ? n - 1 : d;
    if (deff == 0) deff = 1;
    r = 0; h = 0;
    prv = (((n - 1) * m) % n) < deff;
    for (int k = 0; k < n; k++) begin
      cur = ((k * m) % n) < deff;
      if (cur) h++;
      if (cur && !prv) r++;
      prv = cur;
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, r, h, rises, highs, mism, outh, w, p2, s, t0, dur;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check($sformatf("R1 R2 reset read addr %0d", a), v, 0);
    end
    check("R1 clk_level after reset", int'(clk_level), 0);
    check("R1 clk_out after reset", int'(clk_out), 0);

    // R2: readback of staged values and configuration field placement
    stage(3, 7, 4, 3, 2, 2);
    rd(0, v); check("R2 M readback", v, 3);
    rd(1, v); check("R2 N readback", v, (~(7 - 3)) & 8'hFF);
    rd(3, v); check("R2 cfg readback", v, 3 | (2 << 8) | (2 << 12));

    wr(5, 1);
    rd(5, v); check("R2 R10 gate readback", v, 1);

    // vector table
    for (int i = 0; i < 10; i++) begin
      stage(VECS[i].m, VECS[i].n, VECS[i].d, VECS[i].f, VECS[i].src, VECS[i].mode);
      wr(4, 1);
      poll_busy();
      p2 = (VECS[i].f == 0) ? 2 : VECS[i].f + 1;
      s  = VECS[i].src + 1;
      if (VECS[i].mode == 2) begin
        model(VECS[i].m, VECS[i].n, VECS[i].d, r, h);
        w = VECS[i].n * p2 * s;
        measure(w, 1'b1, rises, highs, mism, outh);
        check($sformatf("R3 R4 R5 R6 vec %0d rises", i), rises, 2 * r);
        if ((p2 % 2) == 0)
          check($sformatf("R3 R4 vec %0d high cycles", i), highs, h * p2 * s);
      end else begin
        w = 4 * p2 * s;
        measure(w, 1'b1, rises, highs, mism, outh);
        check($sformatf("R7 R5 R6 vec %0d rises", i), rises, 4);
        if ((p2 % 2) == 0)
          check($sformatf("R7 vec %0d high cycles", i), highs, w / 2);
      end
      check($sformatf("R10 vec %0d out vs level", i), mism, 0);
    end

    // R8: staged values stay inert until the update bit is set
    stage(1, 4, 2, 0, 0, 2);
    wr(4, 1);
    poll_busy();
    stage(2, 5, 2, 0, 1, 2);
    measure(8, 1'b1, rises, highs, mism, outh);
    check("R8 staged not active rises", rises, 2);
    wr(4, 1);
    poll_busy();
    model(2, 5, 2, r, h);
    measure(20, 1'b1, rises, highs, mism, outh);
    check("R8 R9 after commit rises", rises, 2 * r);

    // R10: branch gate
    stage(1, 4, 2, 0, 0, 2);
    wr(4, 1);
    poll_busy();
    wr(5, 0);
    measure(8, 1'b1, rises, highs, mism, outh);
    check("R10 gate off clk_out high", outh, 0);
    check("R10 gate off level still running", rises, 2);
    wr(5, 1);
    measure(8, 1'b1, rises, highs, mism, outh);
    check("R10 gate on match", mism, 0);
    wr(5, 1);
    measure(8, 1'b0, rises, highs, mism, outh);
    check("R10 rewrite gate match", mism, 0);

    // R9: slow active config leaves no boundary, so the wait bound commits
    stage(1, 200, 100, 20, 7, 2);
    wr(4, 1);
    poll_busy();
    wr(4, 1);
    t0 = cyc;
    rd(4, v);
    check("R8 update bit reads set", v & 1, 1);
    poll_busy();
    dur = cyc - t0;
    check("R9 update clears within bound", int'(dur <= TMO + 4), 1);
    check("R9 update waits for bound", int'(dur >= TMO - 4), 1);

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(0, v); check("R1 M after reset", v, 0);
    rd(5, v); check("R1 gate after reset", v, 0);
    measure(16, 1'b0, rises, highs, mism, outh);
    check("R1 clk_out off after reset", outh, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule